// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the off-chip memory strobes for an 8-bit microcontroller core whose code, data or both live in external memory. It runs on the oscillator clock. A machine cycle is 12 oscillator periods, counted by a free-running phase counter that wraps from 11 to 0. Two address-latch pulses and two program-store reads fall in every machine cycle. The core presents its fetch address continuously. It may also request one external data read or write, addressed with either a 16-bit pointer or an 8-bit register-indirect value.

A data request is taken only at phase 5. A taken request spends phases 6 and 7 sending the data address under an address-latch pulse. It then holds the read or write strobe low for 10 oscillator periods, from phase 8 to phase 5 of the next machine cycle. During that window one address-latch pulse and two program-store pulses are left out. Read data is captured in the last strobe clock.

The controller is a three-state machine. FETCH is the idle state with free-running fetch strobes. DADDR is the data address phase. DSTRB is the read or write strobe. Its transitions are:
- take: FETCH to DADDR, at phase 5 with a request present.
- addr_done: DADDR to DSTRB, at phase 7.
- strobe_done: DSTRB to FETCH, at phase 5.

Top module: `xmem_bus_seq`

## Requirements
- R1: While reset is low, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1 and `ad_oe` is 0. The first clock after reset release is phase 0 of a machine cycle.
- R2: With no data access active, `ale` is high in phases 0, 1, 6 and 7 of every cycle: a 2-clock pulse every 6 clocks.
- R3: Each data access leaves out exactly one `ale` pulse, the one at phases 0 and 1 of the cycle after the request.
- R4: For external fetches, `psen_n` is low in phases 3 to 5 and 9 to 11. Each data access leaves out two of these pulses: phases 9 to 11 of the request cycle and phases 3 to 5 of the next cycle.
- R5: A fetch slot is internal when `int_rom_en` is 1 and the fetch address is at most INT_TOP (default 0x1FFF). Then `psen_n` stays high. When `int_rom_en` is 0, every fetch is external. The fetch address and the decision are sampled on the clock edges that enter phases 0 and 6.
- R6: `dreq` is sampled only at phase 5 of a cycle with no access in progress. `ale` pulses for the data address in phases 6 and 7. `rd_n` (if `dwrite`=0) or `wr_n` (if `dwrite`=1) is low from phase 8 through phase 5 of the next cycle. A request at any other phase has no effect.
- R7: During an access, `a_hi` carries `daddr[15:8]` when `dwide`=1, and the `p2_val` captured with the request when `dwide`=0. Otherwise it carries the high fetch address byte.
- R8: `ad_out` carries the low fetch address, with `ad_oe`=1, in phases 0 to 2 and 6 to 8 of a fetch-only cycle, and carries the low data address in phases 6 and 7 of a request. It holds the write data with `ad_oe`=1 for the whole `wr_n` strobe. `ad_oe` is 0 during a read strobe and in all other fetch phases.
- R9: `ad_in` is captured at the last clock of a read strobe. `rdata` holds that value and `rvalid` pulses for one clock, in the clock where `rd_n` returns high.
- R10: `rd_n` and `wr_n` are never low together, and while either is low `psen_n` is 1 and `ale` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_rom_en | input | 1 | 1 lets fetches at or below INT_TOP use internal memory |
| fetch_addr | input | 16 | Address of the next code fetch |
| dreq | input | 1 | External data access request, sampled at phase 5 |
| dwrite | input | 1 | 1 = write, 0 = read |
| dwide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit indirect address |
| daddr | input | 16 | Data address |
| wdata | input | 8 | Write data |
| p2_val | input | 8 | Port-2 latch value, sent high for narrow accesses |
| ad_in | input | 8 | Low byte bus input |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low byte bus output value |
| ad_oe | output | 1 | Low byte bus output enable |
| a_hi | output | 8 | High address byte |
| rdata | output | 8 | Captured read data |
| rvalid | output | 1 | One-clock pulse when `rdata` is updated |

## Verification
The hardest condition to reach from the ports is the exact phase alignment of a request: `dreq` counts only in the single phase-5 clock. The stimulus therefore tracks the phase from reset release and raises `dreq` for exactly that clock. It also sends one request at phase 2, which must be ignored.

The missing pulses are counted over aligned windows of whole machine cycles that mix reads and writes of both address widths. The internal/external boundary is tested with fetch addresses at INT_TOP and INT_TOP+1, with internal memory enabled and then disabled.

// File: rtl/emsq_pkg.sv
package emsq_pkg;
    localparam int PHASES       = 12;
    localparam int PH_W         = $clog2(PHASES);
    localparam int HALF         = PHASES / 2;
    localparam int ALE_W        = 2;
    localparam int ADDR_HOLD    = 3;
    localparam int PSEN_FIRST   = 3;
    localparam int REQ_PH       = 5;
    localparam int DADDR_END_PH = 7;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DADDR,
        ST_DSTRB
    } bus_st_e;

    typedef enum logic [1:0] {
        LO_IDLE,
        LO_FADDR,
        LO_DADDR,
        LO_WDATA
    } lo_sel_e;

    function automatic logic [PH_W-1:0] half_pos(input logic [PH_W-1:0] p);
        return (p >= PH_W'(HALF)) ? p - PH_W'(HALF) : p;
    endfunction
endpackage

// File: rtl/emsq_phase_ctr.sv
module emsq_phase_ctr
    import emsq_pkg::*;
#(
    parameter int N = PHASES,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= W'(N - 1);
        end else if (phase == W'(N - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/emsq_ctrl.sv
module emsq_ctrl
    import emsq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            dreq,
    input  logic            dwrite,
    input  logic            fext,
    output logic            take,
    output logic            fetch_latch,
    output logic            capture,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n,
    output lo_sel_e         lo_sel,
    output logic            hi_data
);
    bus_st_e         st, nxt;
    logic            wr_q;
    logic [PH_W-1:0] hp;

    assign hp = half_pos(phase);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_FETCH;
            wr_q <= 1'b0;
        end else begin
            st <= nxt;
            if (take) begin
                wr_q <= dwrite;
            end
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_FETCH: if (phase == PH_W'(REQ_PH) && dreq) nxt = ST_DADDR;
            ST_DADDR: if (phase == PH_W'(DADDR_END_PH))   nxt = ST_DSTRB;
            ST_DSTRB: if (phase == PH_W'(REQ_PH))         nxt = ST_FETCH;
            default:  nxt = ST_FETCH;
        endcase
    end

    assign take        = (st == ST_FETCH) && (phase == PH_W'(REQ_PH)) && dreq;
    assign fetch_latch = (nxt == ST_FETCH) &&
                         ((phase == PH_W'(PHASES - 1)) || (phase == PH_W'(REQ_PH)));
    assign capture     = (st == ST_DSTRB) && (phase == PH_W'(REQ_PH)) && !wr_q;

    always_comb begin
        ale     = 1'b0;
        psen_n  = 1'b1;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        lo_sel  = LO_IDLE;
        hi_data = 1'b0;
        unique case (st)
            ST_FETCH: begin
                ale    = (hp < PH_W'(ALE_W));
                psen_n = !(fext && (hp >= PH_W'(PSEN_FIRST)));
                lo_sel = (hp < PH_W'(ADDR_HOLD)) ? LO_FADDR : LO_IDLE;
            end
            ST_DADDR: begin
                ale     = 1'b1;
                lo_sel  = LO_DADDR;
                hi_data = 1'b1;
            end
            ST_DSTRB: begin
                hi_data = 1'b1;
                rd_n    = wr_q;
                wr_n    = !wr_q;
                lo_sel  = wr_q ? LO_WDATA : LO_IDLE;
            end
            default: begin
                ale = 1'b0;
            end
        endcase
    end

    a_r2_ale_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);
    a_r4_psen_span: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |=> !psen_n ##1 !psen_n);
    a_r6_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    a_r10_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (psen_n && !ale));
endmodule

// File: rtl/emsq_bus.sv
module emsq_bus
    import emsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] INT_TOP = 'h1FFF,
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              fetch_latch,
    input  logic              capture,
    input  lo_sel_e           lo_sel,
    input  logic              hi_data,
    input  logic              int_rom_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] daddr,
    input  logic              dwide,
    input  logic [DATA_W-1:0] wdata,
    input  logic [HI_W-1:0]   p2_val,
    input  logic [DATA_W-1:0] ad_in,
    output logic              fext,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [ADDR_W-1:0] fa_q, da_q;
    logic [DATA_W-1:0] wd_q;
    logic [HI_W-1:0]   p2_q;
    logic              wide_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_q   <= '0;
            fext   <= 1'b0;
            da_q   <= '0;
            wd_q   <= '0;
            p2_q   <= '0;
            wide_q <= 1'b0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            if (fetch_latch) begin
                fa_q <= fetch_addr;
                fext <= !(int_rom_en && (fetch_addr <= INT_TOP));
            end
            if (take) begin
                da_q   <= daddr;
                wd_q   <= wdata;
                p2_q   <= p2_val;
                wide_q <= dwide;
            end
            rvalid <= capture;
            if (capture) begin
                rdata <= ad_in;
            end
        end
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b1;
        unique case (lo_sel)
            LO_FADDR: ad_out = fa_q[DATA_W-1:0];
            LO_DADDR: ad_out = da_q[DATA_W-1:0];
            LO_WDATA: ad_out = wd_q;
            default:  ad_oe  = 1'b0;
        endcase
    end

    assign a_hi = !hi_data ? fa_q[ADDR_W-1:DATA_W] :
                  (wide_q  ? da_q[ADDR_W-1:DATA_W] : p2_q);
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
    import emsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] INT_TOP = 'h1FFF,
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_rom_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              dreq,
    input  logic              dwrite,
    input  logic              dwide,
    input  logic [ADDR_W-1:0] daddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [HI_W-1:0]   p2_val,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [PH_W-1:0] phase;
    logic            take, fetch_latch, capture, hi_data, fext;
    lo_sel_e         lo_sel;

    emsq_phase_ctr #(.N(PHASES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    emsq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .dreq        (dreq),
        .dwrite      (dwrite),
        .fext        (fext),
        .take        (take),
        .fetch_latch (fetch_latch),
        .capture     (capture),
        .ale         (ale),
        .psen_n      (psen_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .lo_sel      (lo_sel),
        .hi_data     (hi_data)
    );

    emsq_bus #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .INT_TOP (INT_TOP)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .fetch_latch (fetch_latch),
        .capture     (capture),
        .lo_sel      (lo_sel),
        .hi_data     (hi_data),
        .int_rom_en  (int_rom_en),
        .fetch_addr  (fetch_addr),
        .daddr       (daddr),
        .dwide       (dwide),
        .wdata       (wdata),
        .p2_val      (p2_val),
        .ad_in       (ad_in),
        .fext        (fext),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .a_hi        (a_hi),
        .rdata       (rdata),
        .rvalid      (rvalid)
    );

    a_r5_psen_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> fext);
    a_r8_wr_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    a_r8_rd_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    a_r9_valid_at_rd_end: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $rose(rd_n));
endmodule

// File: tb/xmem_bus_seq_bench.sv
module xmem_bus_seq_bench;
    localparam logic [15:0] TOP = 16'h1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_rom_en = 1'b0;
    logic [15:0] fetch_addr = 16'h0000;
    logic        dreq = 1'b0, dwrite = 1'b0, dwide = 1'b0;
    logic [15:0] daddr = 16'h0000;
    logic [7:0]  wdata = 8'h00, p2_val = 8'h00;
    logic [7:0]  ad_in;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, rvalid;
    logic [7:0]  ad_out, a_hi, rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign ad_in = daddr[7:0] ^ 8'hC3;

    always #10 clk = ~clk;

    xmem_bus_seq u_xmem_bus_seq (
        .clk(clk), .rst_n(rst_n), .int_rom_en(int_rom_en), .fetch_addr(fetch_addr),
        .dreq(dreq), .dwrite(dwrite), .dwide(dwide), .daddr(daddr), .wdata(wdata),
        .p2_val(p2_val), .ad_in(ad_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .rdata(rdata),
        .rvalid(rvalid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          m_t = 11, m_win = 0;
    bit          m_ext = 0, m_wr = 0, m_wide = 0, m_rv = 0;
    logic [15:0] m_fa = 0, m_da = 0;
    logic [7:0]  m_wd = 0, m_p2 = 0, m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = 11; m_win = 0; m_ext = 0; m_fa = 0; m_rv = 0;
            m_da = 0; m_wd = 0; m_p2 = 0; m_wide = 0; m_wr = 0; m_rd = 0;
        end else begin
            bit start;
            int nt;
            start = (m_win == 0) && (m_t == 5) && dreq;
            m_rv = 0;
            if (m_win == 1 && !m_wr) begin
                m_rv = 1;
                m_rd = ad_in;
            end
            if (m_win > 0) m_win--;
            if (start) begin
                m_win = 12; m_wr = dwrite; m_wide = dwide;
                m_da = daddr; m_wd = wdata; m_p2 = p2_val;
            end
            nt = (m_t + 1) % 12;
            if (m_win == 0 && (nt == 0 || nt == 6)) begin
                m_fa  = fetch_addr;
                m_ext = !(int_rom_en && fetch_addr <= TOP);
            end
            m_t = nt;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_ale, e_psen_n, e_rd_n, e_wr_n, e_oe;
            logic [7:0] e_out, e_hi;
            if (m_win > 0) begin
                int k;
                k = 12 - m_win;
                e_ale = (k < 2);
                e_psen_n = 1;
                e_rd_n = !(k >= 2 && !m_wr);
                e_wr_n = !(k >= 2 && m_wr);
                e_oe = (k < 2) || (k >= 2 && m_wr);
                e_out = (k < 2) ? m_da[7:0] : m_wd;
                e_hi = m_wide ? m_da[15:8] : m_p2;
            end else begin
                int h;
                h = m_t % 6;
                e_ale = (h < 2);
                e_psen_n = !(m_ext && h >= 3);
                e_rd_n = 1; e_wr_n = 1;
                e_oe = (h <= 2);
                e_out = m_fa[7:0];
                e_hi = m_fa[15:8];
            end
            chk(ale == e_ale, "R2/R3 ale", ale, e_ale);
            chk(psen_n == e_psen_n, "R4/R5 psen_n", psen_n, e_psen_n);
            chk(rd_n == e_rd_n && wr_n == e_wr_n, "R6/R10 rd_n,wr_n",
                {rd_n, wr_n}, {e_rd_n, e_wr_n});
            chk(ad_oe == e_oe, "R8 ad_oe", ad_oe, e_oe);
            if (e_oe) chk(ad_out == e_out, "R8 ad_out", ad_out, e_out);
            chk(a_hi == e_hi, "R7 a_hi", a_hi, e_hi);
            chk(rvalid == m_rv, "R9 rvalid", rvalid, m_rv);
            if (m_rv) chk(rdata == m_rd, "R9 rdata", rdata, m_rd);
        end
    end

    // aligned pulse-count window
    task automatic count_window(input int ncyc, input bit with_acc,
                                output int n_ale, output int n_psen, output int n_rv);
        bit p_ale, p_psen;
        n_ale = 0; n_psen = 0; n_rv = 0;
        do @(negedge clk); while (m_t != 11);
        p_ale = ale; p_psen = psen_n;
        for (int i = 0; i < ncyc * 12; i++) begin
            int c;
            @(negedge clk);
            c = i / 12;
            if (ale && !p_ale) n_ale++;
            if (!psen_n && p_psen) n_psen++;
            if (rvalid) n_rv++;
            p_ale = ale; p_psen = psen_n;
            dreq = 0;
            if (with_acc) begin
                fetch_addr = 16'h2000 + 16'(i * 3);
                if (m_t == 5 && c == 2) begin
                    dreq = 1; dwrite = 0; dwide = 1; daddr = 16'hA35C;
                end else if (m_t == 5 && c == 4) begin
                    dreq = 1; dwrite = 1; dwide = 1; daddr = 16'h5B21; wdata = 8'h9E;
                end else if (m_t == 5 && c == 6) begin
                    dreq = 1; dwrite = 0; dwide = 0; daddr = 16'h0077; p2_val = 8'hD4;
                end else if (m_t == 5 && c == 8) begin
                    dreq = 1; dwrite = 1; dwide = 0; daddr = 16'h00E1;
                    wdata = 8'h3C; p2_val = 8'h6B;
                end else if (m_t == 2 && c == 10) begin
                    dreq = 1; dwrite = 1; dwide = 1; daddr = 16'h7777; // off-phase, R6
                end
            end
        end
        dreq = 0;
    endtask

    initial begin
        int na, np, nr;
        repeat (3) @(negedge clk);
        chk(ale == 0, "R1 ale in reset", ale, 0);
        chk(psen_n == 1 && rd_n == 1 && wr_n == 1, "R1 strobes in reset",
            {psen_n, rd_n, wr_n}, 3'b111);
        chk(ad_oe == 0, "R1 ad_oe in reset", ad_oe, 0);
        rst_n = 1;
        @(negedge clk);
        chk(ale == 1, "R1 phase 0 after release", ale, 1);

        // mixed fetch and data cycles, all fetches external
        int_rom_en = 0;
        count_window(12, 1, na, np, nr);
        chk(na == 20, "R3 ale count with 4 accesses", na, 20);
        chk(np == 16, "R4 psen count with 4 accesses", np, 16);
        chk(nr == 2, "R9 read completions", nr, 2);

        // fetch-only window
        count_window(4, 0, na, np, nr);
        chk(na == 8, "R2 ale count fetch-only", na, 8);
        chk(np == 8, "R4 psen count fetch-only", np, 8);
        chk(nr == 0, "R6 no stray access", nr, 0);

        // internal boundary
        int_rom_en = 1; fetch_addr = TOP;
        count_window(2, 0, na, np, nr);
        chk(np == 0, "R5 top internal address", np, 0);
        chk(na == 4, "R2 ale during internal fetch", na, 4);
        fetch_addr = TOP + 16'd1;
        count_window(2, 0, na, np, nr);
        chk(np == 4, "R5 first external address", np, 4);
        int_rom_en = 0; fetch_addr = 16'h0000;
        count_window(2, 0, na, np, nr);
        chk(np == 4, "R5 forced external", np, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule